// File: doc/BRIEF.md
# Multiplexed 8-bit Parallel Write Sequencer

This block writes bursts of bytes to an asynchronous external memory or memory-mapped peripheral. The peripheral shares sixteen lines between address and data. Every group begins with an address phase, marked by an address latch enable (ALE) strobe. Exactly four byte writes follow, each marked by an active-low write strobe. All timing is counted in whole cycles of the block clock.

During a write, the upper address byte stays on the high half of the bus and the data byte sits on the low half. A host hands over a 16-bit base address and four bytes in a single valid/ready transfer. The block then plays out the group without further host involvement.

Back-pressure works as follows. `in_ready` is high only while the sequencer is idle, and a transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. A transfer whose configuration is illegal is consumed but never played out, and `cfg_err` pulses instead. The host may hold `in_valid` high for as long as it likes; nothing is taken while `in_ready` is low.

The configuration pins are sampled at the transfer and held for the whole group:
- a 5-bit duration D;
- a hold option, giving H = 1 or 0;
- a flash mode, giving a recovery term F = 7 or 0;
- ALE polarity.

Top module: `adbus_wr8_seq`

## Requirements
- R1: After reset: `in_ready`=1, `busy`=0, `done`=0, `cfg_err`=0, `wr_n`=1, `ad_oe`=0, `ad_out`=0, and `ale` sits at its inactive level.
- R2: The first two cycles after an accepted legal transfer form the address phase. In both cycles ALE is active and `ad_out` carries the full 16-bit base address. The active ALE level is high when `cfg_ale_low`=0 and low when it is 1. The inactive level is the inverse. In idle, the level follows the live pin.
- R3: The next two cycles keep the base address on `ad_out` with ALE inactive and `wr_n` high.
- R4: Each group has exactly four write strobes, taking bytes in order from `in_data[7:0]` up to `in_data[31:24]`. Each strobe holds `wr_n` low for D−F cycles. While a byte is being written, `ad_out[15:8]` holds the base address upper byte and `ad_out[7:0]` holds that byte.
- R5: After each strobe, `ad_out` stays unchanged and `wr_n` high for H cycles.
- R6: Between two strobes there are F+1 further cycles with `wr_n` high, and the next byte is already driven during them. The time from one rising edge of `wr_n` to the next falling edge is therefore F+H+1 cycles.
- R7: Configuration is sampled at the transfer. Pin changes during a group have no effect on that group.
- R8: A configuration is illegal when flash mode is set and D≠9, or when D≤F. An illegal transfer pulses `cfg_err` for one cycle and produces no bus activity, and `in_ready` stays high.
- R9: `in_ready`=0 and `busy`=1 for the whole group. `done` pulses for one cycle, in the cycle right after the final hold period. `in_ready` returns the cycle after that.
- R10: `ad_oe` is 1 from the first address cycle to the end of the final hold period and 0 otherwise. `ad_out` is 0 whenever `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a group |
| in_ready | output | 1 | Sequencer idle, able to take a group |
| in_addr | input | 16 | Base address of the group |
| in_data | input | 32 | Four bytes, lowest byte written first |
| cfg_dur | input | 5 | Duration D in cycles |
| cfg_hold | input | 1 | Enables the one-cycle hold term |
| cfg_flash | input | 1 | Flash mode, adds a 7-cycle recovery term |
| cfg_ale_low | input | 1 | Selects active-low ALE |
| ale | output | 1 | Address latch enable, polarity per configuration |
| wr_n | output | 1 | Active-low write strobe |
| ad_oe | output | 1 | Drive enable for the shared bus |
| ad_out | output | 16 | Shared address/data bus value |
| busy | output | 1 | Group in progress |
| done | output | 1 | One-cycle pulse at the end of a group |
| cfg_err | output | 1 | One-cycle pulse when an illegal configuration is rejected |

## Verification
The hardest case is a configuration change in the middle of a group, because a correct design shows nothing at its ports when this happens. The stimulus therefore scrambles every configuration pin, including ALE polarity, right after a transfer is taken. It then compares the whole strobe and bus pattern, cycle by cycle, against timing computed from the values that held at the transfer. Random groups mix flash mode, the hold option and many durations, including the minimum D−F=1 and the maximum D=31. Directed transfers cover each class of illegal configuration.

// File: rtl/adbus_wr8_pkg.sv
package adbus_wr8_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_GAP,
    ST_LOW,
    ST_HOLD,
    ST_REC,
    ST_DONE
  } seq_st_t;
endpackage

// File: rtl/adbus_wr8_cfgchk.sv
module adbus_wr8_cfgchk #(
  parameter int DW        = 5,
  parameter int CW        = 6,
  parameter int FLASH_REC = 7,
  parameter int FLASH_DUR = 9
) (
  input  logic [DW-1:0] dur,
  input  logic          flash,
  input  logic          hold,
  output logic          ok,
  output logic [CW-1:0] lo_len,
  output logic [CW-1:0] rec_len,
  output logic          hold_len
);
  logic [CW-1:0] dur_w;
  logic [CW-1:0] rec_term;

  always_comb begin
    dur_w    = CW'(dur);
    rec_term = flash ? CW'(FLASH_REC) : '0;
    lo_len   = dur_w - rec_term;
    rec_len  = rec_term + CW'(1);
    hold_len = hold;
    ok       = (dur_w > rec_term) && (!flash || (dur_w == CW'(FLASH_DUR)));
  end
endmodule

// File: rtl/adbus_wr8_ctrl.sv
module adbus_wr8_ctrl
  import adbus_wr8_pkg::*;
#(
  parameter int CW      = 6,
  parameter int NB      = 4,
  parameter int ALE_CYC = 2,
  parameter int GAP_CYC = 2,
  localparam int IW     = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          cfg_ok,
  input  logic [CW-1:0] lo_len,
  input  logic [CW-1:0] rec_len,
  input  logic          hold_len,
  input  logic          ale_low_live,
  output logic          in_ready,
  output logic          load,
  output logic          busy,
  output logic          done,
  output logic          cfg_err,
  output logic          ale_lvl,
  output logic          wr_act,
  output logic          oe,
  output logic          addr_phase,
  output logic [IW-1:0] bidx
);
  seq_st_t       st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lo_s, rec_s;
  logic          hold_s, pol_s;
  logic          err_q;
  logic          accept;
  logic          last_byte;

  assign accept    = in_valid && (st_q == ST_IDLE);
  assign load      = accept && cfg_ok;
  assign last_byte = (bidx == IW'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      lo_s   <= CW'(1);
      rec_s  <= CW'(1);
      hold_s <= 1'b0;
      pol_s  <= 1'b0;
      err_q  <= 1'b0;
      bidx   <= '0;
    end else begin
      err_q <= accept && !cfg_ok;
      if (cnt_q != '0 && st_q != ST_IDLE && st_q != ST_DONE) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        unique case (st_q)
          ST_IDLE: if (load) begin
            st_q   <= ST_ALE;
            cnt_q  <= CW'(ALE_CYC - 1);
            lo_s   <= lo_len;
            rec_s  <= rec_len;
            hold_s <= hold_len;
            pol_s  <= ale_low_live;
            bidx   <= '0;
          end
          ST_ALE: begin
            st_q  <= ST_GAP;
            cnt_q <= CW'(GAP_CYC - 1);
          end
          ST_GAP, ST_REC: begin
            st_q  <= ST_LOW;
            cnt_q <= lo_s - CW'(1);
          end
          ST_LOW, ST_HOLD: begin
            if (st_q == ST_LOW && hold_s) begin
              st_q  <= ST_HOLD;
              cnt_q <= '0;
            end else if (last_byte) begin
              st_q <= ST_DONE;
            end else begin
              st_q  <= ST_REC;
              cnt_q <= rec_s - CW'(1);
              bidx  <= bidx + IW'(1);
            end
          end
          ST_DONE: st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign in_ready   = (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign cfg_err    = err_q;
  assign wr_act     = (st_q == ST_LOW);
  assign addr_phase = (st_q == ST_ALE) || (st_q == ST_GAP);
  assign oe         = busy && (st_q != ST_DONE);
  assign ale_lvl    = (st_q == ST_ALE) ^ (busy ? pol_s : ale_low_live);

  AST_ALE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_ALE) |=> (st_q == ST_ALE)) else $error("ALE shorter than 2"); // R2
  AST_ALE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ALE) && $past(st_q == ST_ALE) |=> (st_q == ST_GAP)) else $error("ALE too long"); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(lo_s) && $stable(rec_s) && $stable(hold_s) && $stable(pol_s))
    else $error("config changed mid group"); // R7
  AST_LEGAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lo_s != '0) else $error("zero strobe width"); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && in_ready) else $error("error with activity"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready) else $error("done not a pulse"); // R9
endmodule

// File: rtl/adbus_wr8_busmux.sv
module adbus_wr8_busmux #(
  parameter int AW      = 16,
  parameter int BW      = 8,
  parameter int NB      = 4,
  localparam int IW     = (NB > 1) ? $clog2(NB) : 1,
  localparam int DATA_W = NB * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              oe,
  input  logic              addr_phase,
  input  logic [IW-1:0]     bidx,
  output logic [AW-1:0]     ad_out
);
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BW-1:0]     lane [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = data_q[g*BW +: BW];
  end

  always_comb begin
    if (!oe)             ad_out = '0;
    else if (addr_phase) ad_out = addr_q;
    else                 ad_out = {addr_q[AW-1:BW], lane[bidx]};
  end

  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    oe && $past(oe) |-> ad_out[AW-1:BW] == $past(ad_out[AW-1:BW]))
    else $error("upper lanes moved in group"); // R4
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> ad_out == '0) else $error("bus not quiet"); // R10
endmodule

// File: rtl/adbus_wr8_seq.sv
module adbus_wr8_seq #(
  parameter int AW        = 16,
  parameter int BW        = 8,
  parameter int NB        = 4,
  parameter int DW        = 5,
  parameter int ALE_CYC   = 2,
  parameter int GAP_CYC   = 2,
  parameter int FLASH_REC = 7,
  parameter int FLASH_DUR = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [15:0]    in_addr,
  input  logic [31:0]    in_data,
  input  logic [4:0]     cfg_dur,
  input  logic           cfg_hold,
  input  logic           cfg_flash,
  input  logic           cfg_ale_low,
  output logic           ale,
  output logic           wr_n,
  output logic           ad_oe,
  output logic [15:0]    ad_out,
  output logic           busy,
  output logic           done,
  output logic           cfg_err
);
  localparam int RW = $clog2(FLASH_REC + 2);
  localparam int CW = ((RW > DW) ? RW : DW) + 1;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic          ok;
  logic [CW-1:0] lo_len, rec_len;
  logic          hold_len;
  logic          load, wr_act, oe, addr_phase;
  logic [IW-1:0] bidx;

  adbus_wr8_cfgchk #(.DW(DW), .CW(CW), .FLASH_REC(FLASH_REC), .FLASH_DUR(FLASH_DUR)) chk_i (
    .dur(cfg_dur), .flash(cfg_flash), .hold(cfg_hold),
    .ok(ok), .lo_len(lo_len), .rec_len(rec_len), .hold_len(hold_len)
  );

  adbus_wr8_ctrl #(.CW(CW), .NB(NB), .ALE_CYC(ALE_CYC), .GAP_CYC(GAP_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_ok(ok),
    .lo_len(lo_len), .rec_len(rec_len), .hold_len(hold_len), .ale_low_live(cfg_ale_low),
    .in_ready(in_ready), .load(load), .busy(busy), .done(done), .cfg_err(cfg_err),
    .ale_lvl(ale), .wr_act(wr_act), .oe(oe), .addr_phase(addr_phase), .bidx(bidx)
  );

  adbus_wr8_busmux #(.AW(AW), .BW(BW), .NB(NB)) mux_i (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(in_addr), .data_in(in_data),
    .oe(oe), .addr_phase(addr_phase), .bidx(bidx), .ad_out(ad_out)
  );

  assign wr_n  = !wr_act;
  assign ad_oe = oe;

  AST_WR_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe && busy) else $error("strobe without drive"); // R10
  AST_WR_NOT_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> wr_n) else $error("strobe in address phase"); // R3
endmodule

// File: tb/adbus_wr8_seq_tb_top.sv
module adbus_wr8_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [15:0] in_addr;
  logic [31:0] in_data;
  logic [4:0]  cfg_dur;
  logic        cfg_hold, cfg_flash, cfg_ale_low;
  logic        ale, wr_n, ad_oe, busy, done, cfg_err;
  logic [15:0] ad_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  adbus_wr8_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .cfg_dur(cfg_dur), .cfg_hold(cfg_hold),
    .cfg_flash(cfg_flash), .cfg_ale_low(cfg_ale_low), .ale(ale), .wr_n(wr_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [22:0] pins();
    return {ale, wr_n, ad_oe, ad_out, busy, done, in_ready, cfg_err};
  endfunction

  function automatic void expect_at(input int i, input int l, input int h, input int f,
      input logic [15:0] a, input logic [31:0] d,
      output logic act, output logic wr, output logic oe, output logic dn,
      output logic [15:0] ad, output string tag);
    int t;
    act = 0; wr = 1; oe = 1; dn = 0; ad = a; tag = "R4";
    if (i < 2) begin act = 1; tag = "R2"; return; end
    if (i < 4) begin tag = "R3"; return; end
    t = i - 4;
    for (int k = 0; k < 4; k++) begin
      ad = {a[15:8], d[8*k +: 8]};
      if (t < l) begin wr = 0; tag = "R4"; return; end
      t -= l;
      if (t < h) begin tag = "R5"; return; end
      t -= h;
      if (k < 3) begin
        if (t < f + 1) begin ad = {a[15:8], d[8*(k+1) +: 8]}; tag = "R6"; return; end
        t -= f + 1;
      end
    end
    oe = 0; ad = 0; dn = 1; tag = "R9";
  endfunction

  task automatic run_group(input logic [15:0] a, input logic [31:0] d, input int dur,
      input bit h, input bit fl, input bit pol, input bit scramble);
    int f, l, total;
    bit ok;
    logic act, wr, oe, dn;
    logic [15:0] ad;
    string tag;
    f = fl ? 7 : 0;
    l = dur - f;
    ok = (dur > f) && (!fl || dur == 9);
    @(negedge clk);
    in_addr = a; in_data = d; cfg_dur = dur[4:0]; cfg_hold = h; cfg_flash = fl;
    cfg_ale_low = pol; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    if (!ok) begin
      check("R8", pins(), {pol, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1});
      @(negedge clk);
      check("R8", pins(), {pol, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0});
      return;
    end
    if (scramble) begin
      cfg_dur = 5'($urandom); cfg_hold = 1'($urandom); cfg_flash = 1'($urandom);
      cfg_ale_low = 1'($urandom);
      in_addr = 16'($urandom); in_data = $urandom;
    end
    total = 4 + 4*l + 4*int'(h) + 3*(f + 1) + 1;
    for (int i = 0; i < total; i++) begin
      expect_at(i, l, int'(h), f, a, d, act, wr, oe, dn, ad, tag);
      if (scramble) tag = {tag, "/R7"};
      check(tag, pins(), {act ^ pol, wr, oe, ad, 1'b1, dn, 1'b0, 1'b0});
      @(negedge clk);
    end
    check("R9", pins(), {cfg_ale_low, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; in_valid = 0; in_addr = 0; in_data = 0;
    cfg_dur = 5'd3; cfg_hold = 0; cfg_flash = 0; cfg_ale_low = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", pins(), {1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0});
    cfg_ale_low = 1;
    @(negedge clk);
    check("R2", pins(), {1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0});
    // directed corners
    run_group(16'hA5C3, 32'h44332211, 1, 0, 0, 0, 0);   // minimum strobe
    run_group(16'h1234, 32'hDEADBEEF, 31, 1, 0, 0, 0);  // maximum duration
    run_group(16'hFF00, 32'h0F1E2D3C, 9, 1, 1, 0, 0);   // flash with hold
    run_group(16'h8001, 32'hCAFEF00D, 9, 0, 1, 1, 0);   // flash, active-low ALE
    run_group(16'h3C3C, 32'h89ABCDEF, 4, 1, 0, 1, 1);   // pins scrambled mid group
    run_group(16'h0101, 32'h01020304, 8, 0, 1, 0, 0);   // R8 flash with wrong D
    run_group(16'h0202, 32'h05060708, 0, 1, 0, 1, 0);   // R8 zero duration
    run_group(16'h0303, 32'h090A0B0C, 5, 0, 1, 0, 0);   // R8 D not above F
    for (int n = 0; n < 40; n++) begin
      bit fl;
      int dur;
      fl = ($urandom % 4) == 0;
      dur = fl ? 9 : 1 + ($urandom % 12);
      run_group(16'($urandom), $urandom, dur, 1'($urandom), fl, 1'($urandom),
                1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule